// File: doc/BRIEF.md
# Decode-Stage Hazard Stall Controller

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline may advance. It looks at the source registers of the decoded instruction, whether that instruction is a conditional branch, and the destination, load and write-back flags of the two older instructions now in the execute and memory stages. When a result the decoded instruction needs cannot yet be forwarded, it freezes the program counter and the fetch/decode register and injects a bubble into the execute stage. When a branch is resolved taken by the comparator in decode, it discards the one younger instruction already fetched.

Branches compare their operands in decode, so they need their operands one stage earlier than ALU instructions do. A dependence on the ALU instruction just ahead costs a branch one stall cycle. A dependence on a load two instructions ahead also costs one cycle. A dependence on the load just ahead costs two cycles. The two-cycle case is carried by a small state machine with two states. In RUN the controller stalls only on a hazard visible this cycle. In LOAD_HOLD it stalls unconditionally for the second cycle. The transition ARM goes from RUN to LOAD_HOLD when a branch depends on a load in execute. The transition RELEASE goes from LOAD_HOLD back to RUN on the next cycle. Otherwise RUN stays in RUN. Reset enters RUN.

Top module: `hz_stall_ctrl`

## Requirements
- R1: When the execute-stage instruction is a load (ex_mem_read=1) whose destination is nonzero and equals id_rs, or equals id_rt while id_uses_rt=1, the block stalls in that cycle: pc_we=0, ifid_we=0, idex_bubble=1.
- R2: When no hazard condition of R1, R5, R6 or R7 holds, pc_we=1, ifid_we=1 and idex_bubble=0.
- R3: A destination of register 0 never causes a stall, whatever the stage, load or branch flags.
- R4: When id_uses_rt=0, a match between an older destination and id_rt causes no stall.
- R5: A branch (id_is_branch=1) whose source equals the nonzero destination of a writing, non-load instruction in execute stalls one cycle. The same dependence on a non-branch causes no stall, and neither does an ALU producer in the memory stage.
- R6: A branch whose source equals the nonzero destination of a load in the memory stage stalls one cycle. A non-branch in the same position does not stall.
- R7: A branch whose source equals the nonzero destination of a load in execute stalls for two consecutive cycles.
- R8: ifid_flush=1 exactly when id_is_branch=1, id_br_taken=1 and the block does not stall in that cycle. During a flush, pc_we=1, ifid_we=1 and idex_bubble=0. id_br_taken on a non-branch has no effect.
- R9: During and right after reset, with empty stages, the block does not stall and does not flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_rs | input | REG_BITS | First source register of the decoded instruction |
| id_rt | input | REG_BITS | Second source register of the decoded instruction |
| id_uses_rt | input | 1 | Decoded instruction reads id_rt as a source |
| id_is_branch | input | 1 | Decoded instruction is a conditional branch compared in decode |
| id_br_taken | input | 1 | Decode-stage comparator resolves the branch taken |
| ex_dst | input | REG_BITS | Destination register of the execute-stage instruction |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| mem_dst | input | REG_BITS | Destination register of the memory-stage instruction |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register update enable |
| idex_bubble | output | 1 | Zero the control fields entering execute |
| ifid_flush | output | 1 | Zero the control fields of the fetch/decode register |

## Verification
The bench runs short instruction streams through its own behavioural three-slot pipeline. The streams are load then consumer on rs, on rt, and on an unused rt. They include ALU and load producers at distance one and two ahead of both branches and non-branches, producers writing register 0, and branches resolved taken with and without a pending stall. The consumer-on-rt and unused-rt pairs distinguish a correct source mask from a blanket rt compare. The distance-one and distance-two producers distinguish ALU producers from load producers, and branches from ordinary consumers. The stream of a load followed directly by a taken branch shows whether the second stall cycle is held and whether the flush is withheld until the branch is released.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [0:0] {
        ST_RUN       = 1'b0,
        ST_LOAD_HOLD = 1'b1
    } hz_state_t;

    localparam int unsigned N_PROD = 2;
    localparam int unsigned P_EX   = 0;
    localparam int unsigned P_MEM  = 1;

endpackage

// File: rtl/hz_match.sv
module hz_match #(
    parameter int unsigned REG_BITS = 5
) (
    input  logic [REG_BITS-1:0] src_a,
    input  logic [REG_BITS-1:0] src_b,
    input  logic                src_b_used,
    input  logic [REG_BITS-1:0] prod_dst,
    input  logic                prod_writes,
    output logic                hit
);
    logic dst_live;

    always_comb begin
        dst_live = prod_writes && (prod_dst != '0);
        hit      = dst_live &&
                   ((prod_dst == src_a) || (src_b_used && (prod_dst == src_b)));
    end
endmodule

// File: rtl/hz_seq.sv
module hz_seq
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard_now,
    input  logic arm_hold,
    input  logic id_is_branch,
    input  logic id_br_taken,
    output logic pc_we,
    output logic ifid_we,
    output logic idex_bubble,
    output logic ifid_flush
);
    hz_state_t state_q;
    hz_state_t state_d;
    logic      stall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        stall   = 1'b0;
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN: begin
                stall   = hazard_now;
                state_d = arm_hold ? ST_LOAD_HOLD : ST_RUN;
            end
            ST_LOAD_HOLD: begin
                stall   = 1'b1;
                state_d = arm_hold ? ST_LOAD_HOLD : ST_RUN;
            end
            default: begin
                stall   = 1'b1;
                state_d = ST_RUN;
            end
        endcase
        pc_we       = !stall;
        ifid_we     = !stall;
        idex_bubble = stall;
        ifid_flush  = !stall && id_is_branch && id_br_taken;
    end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned REG_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_BITS-1:0] id_rs,
    input  logic [REG_BITS-1:0] id_rt,
    input  logic                id_uses_rt,
    input  logic                id_is_branch,
    input  logic                id_br_taken,
    input  logic [REG_BITS-1:0] ex_dst,
    input  logic                ex_mem_read,
    input  logic                ex_reg_write,
    input  logic [REG_BITS-1:0] mem_dst,
    input  logic                mem_mem_read,
    input  logic                mem_reg_write,
    output logic                pc_we,
    output logic                ifid_we,
    output logic                idex_bubble,
    output logic                ifid_flush
);
    logic [REG_BITS-1:0] prod_dst    [N_PROD];
    logic                prod_writes [N_PROD];
    logic                prod_hit    [N_PROD];

    logic load_use;
    logic br_on_ex;
    logic br_on_mem_load;
    logic hazard_now;
    logic arm_hold;

    always_comb begin
        prod_dst[P_EX]     = ex_dst;
        prod_writes[P_EX]  = ex_reg_write || ex_mem_read;
        prod_dst[P_MEM]    = mem_dst;
        prod_writes[P_MEM] = mem_reg_write || mem_mem_read;
    end

    for (genvar g = 0; g < N_PROD; g++) begin : g_prod
        hz_match #(.REG_BITS(REG_BITS)) u_match (
            .src_a       (id_rs),
            .src_b       (id_rt),
            .src_b_used  (id_uses_rt),
            .prod_dst    (prod_dst[g]),
            .prod_writes (prod_writes[g]),
            .hit         (prod_hit[g])
        );
    end

    always_comb begin
        load_use       = ex_mem_read && prod_hit[P_EX];
        br_on_ex       = id_is_branch && prod_hit[P_EX];
        br_on_mem_load = id_is_branch && mem_mem_read && prod_hit[P_MEM];
        hazard_now     = load_use || br_on_ex || br_on_mem_load;
        arm_hold       = id_is_branch && ex_mem_read && prod_hit[P_EX];
    end

    hz_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .hazard_now   (hazard_now),
        .arm_hold     (arm_hold),
        .id_is_branch (id_is_branch),
        .id_br_taken  (id_br_taken),
        .pc_we        (pc_we),
        .ifid_we      (ifid_we),
        .idex_bubble  (idex_bubble),
        .ifid_flush   (ifid_flush)
    );
endmodule

// File: rtl/hz_stall_chk.sv
module hz_stall_chk #(
    parameter int unsigned REG_BITS = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [REG_BITS-1:0] id_rs,
    input logic                id_is_branch,
    input logic [REG_BITS-1:0] ex_dst,
    input logic                ex_mem_read,
    input logic                ex_reg_write,
    input logic [REG_BITS-1:0] mem_dst,
    input logic                pc_we,
    input logic                ifid_we,
    input logic                idex_bubble,
    input logic                ifid_flush
);
    a_r1_load_use_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_mem_read && ex_dst != '0 && ex_dst == id_rs) |-> (!pc_we && !ifid_we && idex_bubble));

    a_r3_zero_dst_free: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0 && mem_dst == '0 && $past(ex_dst) == '0) |-> (pc_we && !idex_bubble));

    a_r5_branch_on_alu: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && ex_reg_write && !ex_mem_read && ex_dst != '0 && ex_dst == id_rs) |-> !pc_we);

    a_r7_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && ex_mem_read && ex_dst != '0 && ex_dst == id_rs) |=> (!pc_we && idex_bubble));

    a_r8_flush_clean: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> (pc_we && ifid_we && !idex_bubble && id_is_branch));
endmodule

bind hz_stall_ctrl hz_stall_chk #(.REG_BITS(REG_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_rs        (id_rs),
    .id_is_branch (id_is_branch),
    .ex_dst       (ex_dst),
    .ex_mem_read  (ex_mem_read),
    .ex_reg_write (ex_reg_write),
    .mem_dst      (mem_dst),
    .pc_we        (pc_we),
    .ifid_we      (ifid_we),
    .idex_bubble  (idex_bubble),
    .ifid_flush   (ifid_flush)
);

// File: tb/test_hz_stall_ctrl.sv
`timescale 1ns/1ps
module test_hz_stall_ctrl;
    localparam int RB = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RB-1:0] id_rs = '0, id_rt = '0, ex_dst = '0, mem_dst = '0;
    logic          id_uses_rt = 0, id_is_branch = 0, id_br_taken = 0;
    logic          ex_mem_read = 0, ex_reg_write = 0, mem_mem_read = 0, mem_reg_write = 0;
    logic          pc_we, ifid_we, idex_bubble, ifid_flush;

    always #2.5 clk = ~clk;

    hz_stall_ctrl #(.REG_BITS(RB)) i_hz_stall_ctrl (
        .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt), .id_uses_rt(id_uses_rt),
        .id_is_branch(id_is_branch), .id_br_taken(id_br_taken), .ex_dst(ex_dst),
        .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write), .mem_dst(mem_dst),
        .mem_mem_read(mem_mem_read), .mem_reg_write(mem_reg_write), .pc_we(pc_we),
        .ifid_we(ifid_we), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush));

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // program: one entry per instruction
    int    n = 0;
    int    p_rs[64], p_rt[64], p_dst[64];
    bit    p_ur[64], p_br[64], p_tk[64], p_ld[64], p_wr[64];
    string p_tag[64];

    task automatic add(int rs, int rt, bit ur, bit br, bit tk, int dst, bit ld, bit wr, string tag);
        p_rs[n] = rs; p_rt[n] = rt; p_ur[n] = ur; p_br[n] = br; p_tk[n] = tk;
        p_dst[n] = dst; p_ld[n] = ld; p_wr[n] = wr; p_tag[n] = tag;
        n++;
    endtask

    task automatic nop();
        add(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    endtask

    function automatic bit feeds(int p, int c);
        if (p < 0 || c < 0) return 0;
        if (!p_wr[p] || p_dst[p] == 0) return 0;
        return (p_dst[p] == p_rs[c]) || (p_ur[c] && p_dst[p] == p_rt[c]);
    endfunction

    task automatic chk(string tag, string what, bit got, bit exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b expected %b", tag, what, got, exp);
        end
    endtask

    task automatic drive(int id_i, int ex_i, int mem_i);
        id_rs        = (id_i < 0) ? '0 : RB'(p_rs[id_i]);
        id_rt        = (id_i < 0) ? '0 : RB'(p_rt[id_i]);
        id_uses_rt   = (id_i < 0) ? 1'b0 : p_ur[id_i];
        id_is_branch = (id_i < 0) ? 1'b0 : p_br[id_i];
        id_br_taken  = (id_i < 0) ? 1'b0 : p_tk[id_i];
        ex_dst       = (ex_i < 0) ? '0 : RB'(p_dst[ex_i]);
        ex_mem_read  = (ex_i < 0) ? 1'b0 : p_ld[ex_i];
        ex_reg_write = (ex_i < 0) ? 1'b0 : p_wr[ex_i];
        mem_dst      = (mem_i < 0) ? '0 : RB'(p_dst[mem_i]);
        mem_mem_read = (mem_i < 0) ? 1'b0 : p_ld[mem_i];
        mem_reg_write= (mem_i < 0) ? 1'b0 : p_wr[mem_i];
    endtask

    initial begin
        // R1 load then consumer on rs, then on rt
        add(1, 2, 1, 0, 0, 5, 1, 1, "R2"); add(5, 1, 1, 0, 0, 8, 0, 1, "R1"); nop(); nop();
        add(1, 2, 1, 0, 0, 7, 1, 1, "R2"); add(3, 7, 1, 0, 0, 8, 0, 1, "R1"); nop(); nop();
        // R4 rt matches but unused
        add(1, 2, 1, 0, 0, 7, 1, 1, "R2"); add(1, 7, 0, 0, 0, 8, 0, 1, "R4"); nop(); nop();
        // R3 producers of register 0
        add(1, 2, 1, 0, 0, 0, 1, 1, "R2"); add(0, 0, 1, 1, 0, 0, 0, 0, "R3"); nop(); nop();
        // R5 ALU then branch, ALU then non-branch, ALU two ahead of branch
        add(1, 2, 1, 0, 0, 3, 0, 1, "R2"); add(3, 4, 1, 1, 0, 0, 0, 0, "R5"); nop(); nop();
        add(1, 2, 1, 0, 0, 3, 0, 1, "R2"); add(3, 4, 1, 0, 0, 9, 0, 1, "R5"); nop(); nop();
        add(1, 2, 1, 0, 0, 3, 0, 1, "R2"); nop(); add(3, 4, 1, 1, 0, 0, 0, 0, "R5"); nop(); nop();
        // R6 load two ahead of branch / of non-branch
        add(1, 2, 1, 0, 0, 4, 1, 1, "R2"); nop(); add(1, 4, 1, 1, 0, 0, 0, 0, "R6"); nop(); nop();
        add(1, 2, 1, 0, 0, 4, 1, 1, "R2"); nop(); add(4, 1, 1, 0, 0, 9, 0, 1, "R6"); nop(); nop();
        // R7 load just ahead of taken branch: two stalls then flush
        add(1, 2, 1, 0, 0, 6, 1, 1, "R2"); add(6, 0, 1, 1, 1, 0, 0, 0, "R7"); nop(); nop();
        // R8 taken branch with no hazard, taken flag on non-branch, ALU then taken branch
        add(1, 2, 1, 1, 1, 0, 0, 0, "R8"); nop(); nop();
        add(1, 2, 1, 0, 1, 9, 0, 1, "R8"); nop(); nop();
        add(1, 2, 1, 0, 0, 9, 0, 1, "R2"); add(2, 9, 1, 1, 1, 0, 0, 0, "R8"); nop(); nop();

        // R9 reset state
        drive(-1, -1, -1);
        repeat (3) @(negedge clk);
        #1;
        chk("R9", "pc_we in reset", pc_we, 1'b1);
        chk("R9", "flush in reset", ifid_flush, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9", "bubble after reset", idex_bubble, 1'b0);
        chk("R9", "ifid_we after reset", ifid_we, 1'b1);

        begin
            int id_i = -1, ex_i = -1, mem_i = -1, pc = 0;
            int drain = 0;
            while (drain < 4) begin
                bit stall, flush;
                string tag;
                @(negedge clk);
                drive(id_i, ex_i, mem_i);
                #1;
                stall = (ex_i >= 0 && p_ld[ex_i] && feeds(ex_i, id_i)) ||
                        (id_i >= 0 && p_br[id_i] && feeds(ex_i, id_i)) ||
                        (id_i >= 0 && p_br[id_i] && mem_i >= 0 && p_ld[mem_i] && feeds(mem_i, id_i));
                flush = !stall && id_i >= 0 && p_br[id_i] && p_tk[id_i];
                tag = (id_i < 0) ? "R2" : p_tag[id_i];
                chk(tag, "pc_we", pc_we, !stall);
                chk(tag, "ifid_we", ifid_we, !stall);
                chk(tag, "idex_bubble", idex_bubble, stall);
                chk(tag, "ifid_flush", ifid_flush, flush);
                mem_i = ex_i;
                if (stall) begin
                    ex_i = -1;
                end else begin
                    ex_i = id_i;
                    if (flush) id_i = -1;
                    else if (pc < n) begin id_i = pc; pc++; end
                    else id_i = -1;
                end
                if (pc >= n && id_i < 0 && ex_i < 0 && mem_i < 0) drain++;
            end
        end
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule